// File: doc/BRIEF.md
# Zero-Slack Path-Delay Test Sequencer

This controller runs a scan-based path-delay test from a slow test clock. Each entry of an external vector store describes one path. The entry holds a launch vector, a second vector that drives the opposite value at the path's destination flop, the expected response and the path's expected delay. For each entry the sequencer shifts the launch vector into the scan chain and then presents the second vector on a parallel output, so that a transition travels down the path. It then raises a detection-mode select, which makes the clock multiplexer in every capture flop take a copy of the system clock shifted by the path delay. The capture edge therefore has zero slack. Last, the sequencer shifts the captured chain out and compares it bit by bit with the expected response. A mismatch means the path is slower than expected, which is what a hardware Trojan on that path causes.

The detection-mode select changes only on a falling edge of the test clock, and each of its levels lasts at least two test-clock cycles. This is the minimum pulse-width rule of the clock multiplexer. Once the select is raised it stays high until the run is over, because both clocks have the same frequency. A path whose expected delay is below the test resolution cannot be measured and is skipped. The result is a sticky fail flag together with the index of the first failing entry and the first failing bit.

Top module: `pd_zero_slack_seq`

## Requirements
- R1: While reset is low and after its release, scan_en, det_mode, done, fail and pi_vec are all 0.
- R2: For each tested entry, scan_en is high for exactly CHAIN_LEN consecutive cycles of shift-in. The cycle after the start cycle is a selection cycle. Shift-in follows it, and in shift-in cycle j, chain_si carries bit CHAIN_LEN-1-j of vec_launch, so the highest bit goes first. The chain model is chain <= {chain[N-2:0], chain_si}, and chain_so is chain[N-1].
- R3: After shift-in, scan_en is low for exactly 2+ARM_CYCLES cycles: launch, ARM_CYCLES arming cycles and capture. During these cycles pi_vec equals vec_second. pi_vec is 0 in all other cycles.
- R4: det_mode changes only on a falling clock edge. It rises at the falling edge inside the first arming cycle of the first tested entry and stays high for the rest of the run. It falls at the falling edge after done rises. Each of its levels lasts at least two clock cycles.
- R5: After capture, scan_en is high for exactly CHAIN_LEN cycles of shift-out. In shift-out cycle k, chain_so is compared with bit CHAIN_LEN-1-k of vec_expect.
- R6: fail is sticky for the whole run. fail_test holds the index of the first entry that mismatched. fail_bit holds that entry's first mismatching bit in shift-out order, which is the highest-numbered differing bit.
- R7: An entry with vec_delay < RESOLUTION gets no shift, launch or capture cycles and can never set fail. An entry with vec_delay equal to RESOLUTION is tested.
- R8: A run from start to done takes 1+NUM_TESTS selection cycles plus 2*CHAIN_LEN+3+ARM_CYCLES cycles per tested entry. done then stays high until the next start. A start in idle clears done, fail, fail_test and fail_bit. A start during a run has no effect.
- R9: vec_addr selects entries 0 to NUM_TESTS-1 in ascending order and is held constant during every shift burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| done | output | 1 | Run complete, held until next start |
| scan_en | output | 1 | Scan-shift enable to the chain |
| chain_si | output | 1 | Serial data into the chain |
| chain_so | input | 1 | Serial data out of the chain |
| det_mode | output | 1 | Selects the phase-shifted clock in capture flops |
| vec_addr | output | $clog2(NUM_TESTS) | Vector store entry index |
| vec_launch | input | CHAIN_LEN | Launch vector of the entry |
| vec_second | input | CHAIN_LEN | Transition vector of the entry |
| vec_expect | input | CHAIN_LEN | Known-good captured response |
| vec_delay | input | DELAY_W | Expected path delay in phase-step units |
| pi_vec | output | CHAIN_LEN | Second vector applied to the logic under test |
| fail | output | 1 | Sticky mismatch flag |
| fail_test | output | $clog2(NUM_TESTS) | Index of first failing entry |
| fail_bit | output | $clog2(CHAIN_LEN) | First failing bit of that entry |

## Verification
Seven fault and skip patterns are run against a chain model that captures launch XOR second XOR an injected slow-path mask. Runs with no fault tell a real mismatch apart from a miscompare. A fault only on bit 0 or only on bit 7 exposes errors in bit order and in the reported index. Two faulted entries check that the first failure is the one reported. A fault placed on a skipped entry, and a run with every entry skipped, separate the resolution gate from the compare path. The cycle-by-cycle trace of the first entry pins down the shift order, the width of the launch/capture window and the falling-edge placement of det_mode. A start pulse in mid-run must leave both the cycle count and the result unchanged.

// File: rtl/pd_zero_slack_seq.sv
module pd_zero_slack_seq #(
  parameter int CHAIN_LEN  = 8,
  parameter int NUM_TESTS  = 4,
  parameter int DELAY_W    = 8,
  parameter int RESOLUTION = 20,
  parameter int ARM_CYCLES = 2
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            start,
  output logic                                            done,
  output logic                                            scan_en,
  output logic                                            chain_si,
  input  logic                                            chain_so,
  output logic                                            det_mode,
  output logic [((NUM_TESTS > 1) ? $clog2(NUM_TESTS) : 1)-1:0] vec_addr,
  input  logic [CHAIN_LEN-1:0]                            vec_launch,
  input  logic [CHAIN_LEN-1:0]                            vec_second,
  input  logic [CHAIN_LEN-1:0]                            vec_expect,
  input  logic [DELAY_W-1:0]                              vec_delay,
  output logic [CHAIN_LEN-1:0]                            pi_vec,
  output logic                                            fail,
  output logic [((NUM_TESTS > 1) ? $clog2(NUM_TESTS) : 1)-1:0] fail_test,
  output logic [((CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1)-1:0] fail_bit
);
  localparam int AW = (NUM_TESTS > 1) ? $clog2(NUM_TESTS) : 1;
  localparam int TW = $clog2(NUM_TESTS + 1);
  localparam int BW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam int CW = $clog2(CHAIN_LEN + ARM_CYCLES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SHIFT_IN, S_LAUNCH, S_ARM_DM, S_CAPTURE, S_SHIFT_OUT, S_COMPARE, S_NEXT
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tidx;
  logic          dm_req;
  logic          dm_q;
  logic          tmis;
  logic [BW-1:0] tbit;
  logic [BW-1:0] bit_pos;

  assign bit_pos  = BW'(CHAIN_LEN - 1 - int'(cnt));
  assign scan_en  = (st == S_SHIFT_IN) || (st == S_SHIFT_OUT);
  assign chain_si = (st == S_SHIFT_IN) ? vec_launch[bit_pos] : 1'b0;
  assign pi_vec   = (st == S_LAUNCH || st == S_ARM_DM || st == S_CAPTURE) ? vec_second : '0;
  assign vec_addr = tidx[AW-1:0];
  assign det_mode = dm_q;

  wire last_shift = (cnt == CW'(CHAIN_LEN - 1));
  wire last_arm   = (cnt == CW'(ARM_CYCLES - 1));
  wire too_short  = (vec_delay < DELAY_W'(RESOLUTION));
  wire at_end     = (tidx == TW'(NUM_TESTS));
  wire bit_bad    = (chain_so != vec_expect[bit_pos]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      tidx      <= '0;
      dm_req    <= 1'b0;
      tmis      <= 1'b0;
      tbit      <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_test <= '0;
      fail_bit  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st        <= S_NEXT;
          tidx      <= '0;
          done      <= 1'b0;
          fail      <= 1'b0;
          fail_test <= '0;
          fail_bit  <= '0;
        end
        S_NEXT: begin
          if (at_end) begin
            st     <= S_IDLE;
            done   <= 1'b1;
            dm_req <= 1'b0;
          end else if (too_short) begin
            tidx <= tidx + TW'(1);
          end else begin
            st   <= S_SHIFT_IN;
            cnt  <= '0;
            tmis <= 1'b0;
          end
        end
        S_SHIFT_IN: begin
          cnt <= cnt + CW'(1);
          if (last_shift) begin
            st  <= S_LAUNCH;
            cnt <= '0;
          end
        end
        S_LAUNCH: begin
          st     <= S_ARM_DM;
          dm_req <= 1'b1;
          cnt    <= '0;
        end
        S_ARM_DM: begin
          if (last_arm) begin
            st  <= S_CAPTURE;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_CAPTURE: begin
          st  <= S_SHIFT_OUT;
          cnt <= '0;
        end
        S_SHIFT_OUT: begin
          if (bit_bad && !tmis) begin
            tmis <= 1'b1;
            tbit <= bit_pos;
          end
          cnt <= cnt + CW'(1);
          if (last_shift) st <= S_COMPARE;
        end
        S_COMPARE: begin
          if (tmis && !fail) begin
            fail      <= 1'b1;
            fail_test <= vec_addr;
            fail_bit  <= tbit;
          end
          tidx <= tidx + TW'(1);
          st   <= S_NEXT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dm_q <= 1'b0;
    else        dm_q <= dm_req;
  end

  logic          dm_prev;
  logic [1:0]    dm_hold;
  logic          se_prev;
  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dm_prev <= 1'b0;
      dm_hold <= 2'd2;
      se_prev <= 1'b0;
      run_len <= '0;
    end else begin
      dm_prev <= det_mode;
      dm_hold <= (det_mode != dm_prev) ? 2'd1 : ((dm_hold == 2'd3) ? 2'd3 : dm_hold + 2'd1);
      se_prev <= scan_en;
      run_len <= scan_en ? run_len + CW'(1) : '0;
    end
  end

  assert_dm_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (det_mode != dm_prev) |-> (dm_hold >= 2'd2));

  assert_dm_rise_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_mode) |-> (!scan_en && (pi_vec == vec_second)));

  assert_shift_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (se_prev && !scan_en) |-> (run_len == CW'(CHAIN_LEN)));

  assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> (fail && $stable(fail_test) && $stable(fail_bit)));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scan_en && !det_mode && (pi_vec == '0)));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && se_prev) |-> $stable(vec_addr));
endmodule

// File: tb/pd_zero_slack_seq_tb.sv
module pd_zero_slack_seq_tb_top;
  localparam int CLK_P = 8;
  localparam int N     = 8;
  localparam int NT    = 4;
  localparam int RES   = 20;
  localparam int ARM   = 2;
  localparam int PER_TEST = 2 * N + 3 + ARM;

  typedef struct packed {
    logic [3:0] skip;
    logic [1:0] ft0;
    logic [7:0] m0;
    logic [1:0] ft1;
    logic [7:0] m1;
    logic       efail;
    logic [1:0] etest;
    logic [2:0] ebit;
  } row_t;

  localparam row_t ROWS [7] = '{
    '{4'b0000, 2'd0, 8'h00, 2'd0, 8'h00, 1'b0, 2'd0, 3'd0},
    '{4'b0000, 2'd2, 8'h10, 2'd0, 8'h00, 1'b1, 2'd2, 3'd4},
    '{4'b0000, 2'd1, 8'h05, 2'd3, 8'h80, 1'b1, 2'd1, 3'd2},
    '{4'b0010, 2'd1, 8'hFF, 2'd0, 8'h00, 1'b0, 2'd0, 3'd0},
    '{4'b0001, 2'd0, 8'h01, 2'd3, 8'h01, 1'b1, 2'd3, 3'd0},
    '{4'b1111, 2'd0, 8'hFF, 2'd0, 8'h00, 1'b0, 2'd0, 3'd0},
    '{4'b0000, 2'd0, 8'h80, 2'd0, 8'h00, 1'b1, 2'd0, 3'd7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, scan_en, chain_si, chain_so, det_mode, fail;
  logic [1:0] vec_addr, fail_test;
  logic [2:0] fail_bit;
  logic [N-1:0] vec_launch, vec_second, vec_expect, pi_vec;
  logic [7:0] vec_delay;
  row_t cur = '0;

  always #(CLK_P / 2) clk = ~clk;

  function automatic logic [N-1:0] launch_f(input logic [1:0] a);
    return 8'h3C ^ (8'(a) * 8'h29);
  endfunction
  function automatic logic [N-1:0] second_f(input logic [1:0] a);
    return 8'h96 ^ (8'(a) * 8'h11);
  endfunction
  function automatic logic [N-1:0] fault_f(input logic [1:0] a);
    return ((a == cur.ft0) ? cur.m0 : 8'h00) | ((a == cur.ft1) ? cur.m1 : 8'h00);
  endfunction

  assign vec_launch = launch_f(vec_addr);
  assign vec_second = second_f(vec_addr);
  assign vec_expect = launch_f(vec_addr) ^ second_f(vec_addr);
  assign vec_delay  = cur.skip[vec_addr] ? 8'(RES - 1) : 8'(RES + 3 * int'(vec_addr));

  logic [N-1:0] chain, base;
  always @(posedge clk) begin
    if (scan_en) begin
      chain <= {chain[N-2:0], chain_si};
      base  <= {chain[N-2:0], chain_si};
    end else begin
      chain <= base ^ pi_vec ^ fault_f(vec_addr);
    end
  end
  assign chain_so = chain[N-1];

  pd_zero_slack_seq #(.CHAIN_LEN(N), .NUM_TESTS(NT), .DELAY_W(8), .RESOLUTION(RES), .ARM_CYCLES(ARM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .scan_en(scan_en),
    .chain_si(chain_si), .chain_so(chain_so), .det_mode(det_mode), .vec_addr(vec_addr),
    .vec_launch(vec_launch), .vec_second(vec_second), .vec_expect(vec_expect),
    .vec_delay(vec_delay), .pi_vec(pi_vec), .fail(fail), .fail_test(fail_test), .fail_bit(fail_bit)
  );

  int checks = 0;
  int errors = 0;
  int glitches = 0;
  logic dm_late = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_P / 4);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P / 4);
      if (det_mode !== dm_late) glitches++;
      @(negedge clk);
      #(CLK_P / 4);
      dm_late = det_mode;
    end
  end

  logic se_h [0:255];
  logic si_h [0:255];
  logic dm_h [0:255];
  logic [N-1:0] pi_h [0:255];
  int n_scan, n_pi, n_cyc;
  logic [3:0] scan_mask;
  bit addr_order_ok;

  task automatic run(input row_t r, input int busy_at);
    int last_addr;
    cur = r;
    n_scan = 0; n_pi = 0; n_cyc = 0;
    scan_mask = '0; addr_order_ok = 1'b1; last_addr = 0;
    start = 1'b1;
    step();
    start = 1'b0;
    while (!done && n_cyc < 250) begin
      se_h[n_cyc] = scan_en;
      si_h[n_cyc] = chain_si;
      dm_h[n_cyc] = det_mode;
      pi_h[n_cyc] = pi_vec;
      if (scan_en) begin
        n_scan++;
        scan_mask[vec_addr] = 1'b1;
        if (int'(vec_addr) < last_addr) addr_order_ok = 1'b0;
        last_addr = int'(vec_addr);
      end
      if (pi_vec != '0) begin
        n_pi++;
        if (pi_vec != second_f(vec_addr)) addr_order_ok = 1'b0;
      end
      start = (n_cyc == busy_at);
      step();
      n_cyc++;
    end
    start = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step();
    chk(!scan_en && !det_mode && !done && !fail && pi_vec == '0, "R1", "outputs in reset", int'(scan_en), 0);
    step();
    rst_n = 1'b1;
    step(); step();
    chk(!scan_en, "R1", "scan_en after reset", int'(scan_en), 0);
    chk(!det_mode, "R1", "det_mode after reset", int'(det_mode), 0);
    chk(!done && !fail, "R1", "done/fail after reset", int'({done, fail}), 0);
    chk(pi_vec == '0, "R1", "pi_vec after reset", int'(pi_vec), 0);

    // directed trace of the first entry, row 0 (nothing skipped or faulted)
    run(ROWS[0], -1);
    begin
      logic [N-1:0] si_seen;
      bit win_ok, out_ok;
      si_seen = '0;
      chk(!se_h[0], "R2", "selection cycle has no shift", int'(se_h[0]), 0);
      for (int j = 1; j <= N; j++) begin
        si_seen = {si_seen[N-2:0], si_h[j]};
        if (!se_h[j]) chk(1'b0, "R2", "scan_en during shift-in", j, 1);
      end
      chk(si_seen == launch_f(2'd0), "R2", "shift-in order msb first", int'(si_seen), int'(launch_f(2'd0)));
      win_ok = 1'b1;
      for (int j = N + 1; j <= N + 2 + ARM; j++)
        if (se_h[j] || pi_h[j] != second_f(2'd0)) win_ok = 1'b0;
      chk(win_ok, "R3", "launch/capture window", int'(pi_h[N + 1]), int'(second_f(2'd0)));
      chk(se_h[N + 3 + ARM], "R3", "window ends after 2+ARM cycles", int'(se_h[N + 3 + ARM]), 1);
      chk(pi_h[N] == '0 && pi_h[N + 3 + ARM] == '0, "R3", "pi_vec zero outside window", int'(pi_h[N]), 0);
      chk(!dm_h[N + 1] && !dm_h[N + 2], "R4", "det_mode low before arming edge", int'(dm_h[N + 2]), 0);
      chk(dm_h[N + 3], "R4", "det_mode high after first arm falling edge", int'(dm_h[N + 3]), 1);
      out_ok = 1'b1;
      for (int j = N + 3 + ARM; j < 2 * N + 3 + ARM; j++) if (!se_h[j]) out_ok = 1'b0;
      chk(out_ok && !se_h[2 * N + 3 + ARM], "R5", "shift-out length", n_scan, 2 * N * NT);
      chk(dm_h[n_cyc - 1], "R4", "det_mode held high to end of run", int'(dm_h[n_cyc - 1]), 1);
    end
    chk(det_mode, "R4", "det_mode still high in done cycle", int'(det_mode), 1);
    step();
    chk(!det_mode, "R4", "det_mode low after done", int'(det_mode), 0);
    chk(done, "R8", "done held in idle", int'(done), 1);

    // table of fault and skip patterns
    for (int r = 0; r < 7; r++) begin
      int k;
      k = NT - $countones(ROWS[r].skip);
      run(ROWS[r], -1);
      chk(done, "R8", $sformatf("row %0d done", r), int'(done), 1);
      chk(n_cyc == 1 + NT + k * PER_TEST, "R8", $sformatf("row %0d run length", r), n_cyc, 1 + NT + k * PER_TEST);
      chk(n_scan == 2 * N * k, "R7", $sformatf("row %0d shift cycles", r), n_scan, 2 * N * k);
      chk(n_pi == (2 + ARM) * k, "R3", $sformatf("row %0d window cycles", r), n_pi, (2 + ARM) * k);
      chk(scan_mask == ~ROWS[r].skip && addr_order_ok, "R9", $sformatf("row %0d entry order", r),
          int'(scan_mask), int'(~ROWS[r].skip));
      chk(fail == ROWS[r].efail, "R6", $sformatf("row %0d fail", r), int'(fail), int'(ROWS[r].efail));
      if (ROWS[r].efail) begin
        chk(fail_test == ROWS[r].etest, "R6", $sformatf("row %0d first test", r), int'(fail_test), int'(ROWS[r].etest));
        chk(fail_bit == ROWS[r].ebit, "R5", $sformatf("row %0d first bit", r), int'(fail_bit), int'(ROWS[r].ebit));
      end
      step(); step();
      chk(fail == ROWS[r].efail && !det_mode, "R6", $sformatf("row %0d sticky in idle", r), int'(fail), int'(ROWS[r].efail));
    end

    // start after a failing run clears the result
    start = 1'b1;
    cur = ROWS[0];
    step();
    start = 1'b0;
    chk(!fail && !done, "R8", "start clears fail and done", int'({fail, done}), 0);
    while (!done && n_cyc < 250) step();
    chk(!fail, "R8", "clean run after clear", int'(fail), 0);

    // start pulse in the middle of a run
    run(ROWS[1], 30);
    chk(n_cyc == 1 + NT + NT * PER_TEST, "R8", "busy start ignored length", n_cyc, 1 + NT + NT * PER_TEST);
    chk(fail && fail_test == 2'd2 && fail_bit == 3'd4, "R8", "busy start ignored result", int'(fail_test), 2);

    step();
    chk(glitches == 0, "R4", "det_mode changes only on falling edges", glitches, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule